// File: doc/BRIEF.md
# System Status Word with Sticky Event Flags

This block gives software one read-only status word for a low-power embedded controller. The word has four kinds of field. Some are live copies of external pins, a few of them inverted. Some are sticky flags, set by a pin edge or by the cause of the last reset. One is a four-bit display identity code, sampled from the display data lines until the display controller is switched on. The last is the state of a six-stage divider that turns a 64 Hz tick into the once-per-second increment for the real-time clock.

All asynchronous pins pass through a two-flop synchroniser before they are shown or edge-detected. The reset-cause and battery flags sit in a power-on reset domain, so they survive the system reset that they record. The wake flag sits in the system reset domain. It is cleared by a write strobe for either low-power mode entry. The other sticky flags are cleared by a separate flag-clear strobe. When a set event and a clear come in the same cycle, the set takes effect.

Top module: `sys_status_word`

## Requirements
- R1: Bit 0 shows the inverse of `media_chg_pin`, two clock edges after the pin changes.
- R2: Bit 1 shows the inverse of the active-low `ext_pwr_n_pin`, two clock edges after the pin changes.
- R3: Bit 2 shows the synchronised live level of `wake_pin`, not latched.
- R4: Bit 3 sets on a rising edge of the synchronised `wake_pin`. A `halt_wr` or `stdby_wr` strobe clears it, and so does system reset (`rst_n` low).
- R5: Bits 7:4 follow the synchronised `lcd_data_pin` while `lcd_en` is low. From the first edge at which `lcd_en` is high, they hold the last value captured.
- R6: Bits 8, 9 and 10 show the synchronised `cts_pin`, `dsr_pin` and `dcd_pin`. Bit 11 shows `uart_tx_busy` directly.
- R7: Bit 12 sets on a low-to-high transition of the synchronised `bat_chg_n_pin`. Only `clr_wr` clears it. `halt_wr`, `stdby_wr` and system reset leave it unchanged.
- R8: Bit 13 sets while `rst_by_user` is high, and bit 14 sets while `rst_by_pwrfail` is high. Both hold through system reset and are cleared by `clr_wr`.
- R9: Bit 15 is 1 after power-on reset (`por_n` low) and is cleared by `clr_wr`. Nothing except power-on reset sets it again, including system reset.
- R10: When a set event for a sticky flag comes in the same cycle as its clear strobe, the flag ends up set.
- R11: Bits 21:16 hold the number of 64 Hz ticks counted since the last wrap, with the bit order reversed. Bit 21 is the fastest stage (count bit 0, 32 Hz) and bit 16 is the slowest (count bit 5, 1 Hz). System reset clears the count.
- R12: On the 64th `tick64`, the count wraps to 0 and `rtc_inc` is high for exactly one cycle.
- R13: Bits 31:22 always read 0, and `rd_data` is all zeros while `rd_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, asynchronous, active low |
| rd_sel | input | 1 | Read select for the status word |
| rd_data | output | 32 | Status word (zero when not selected) |
| clr_wr | input | 1 | Flag-clear write strobe |
| halt_wr | input | 1 | Halt-mode entry write strobe |
| stdby_wr | input | 1 | Standby-mode entry write strobe |
| media_chg_pin | input | 1 | Media-changed pin, asynchronous |
| ext_pwr_n_pin | input | 1 | External power present, active low, asynchronous |
| wake_pin | input | 1 | Wakeup pin, asynchronous |
| lcd_data_pin | input | 4 | Display data lines, asynchronous |
| cts_pin | input | 1 | Modem clear-to-send, asynchronous |
| dsr_pin | input | 1 | Modem data-set-ready, asynchronous |
| dcd_pin | input | 1 | Modem carrier-detect, asynchronous |
| bat_chg_n_pin | input | 1 | Battery-change pin, asynchronous |
| lcd_en | input | 1 | Display controller enable |
| uart_tx_busy | input | 1 | UART transmitter busy |
| rst_by_user | input | 1 | Reset cause: user reset button |
| rst_by_pwrfail | input | 1 | Reset cause: power-fail pin |
| tick64 | input | 1 | 64 Hz tick, one-cycle pulse |
| rtc_inc | output | 1 | One-cycle 1 Hz increment pulse to the RTC |

## Verification
A vector table drives the live pin fields with patterns that set each pin against its neighbours. Every field then differs between at least two rows, so a swapped or non-inverted bit shows up. Directed sequences test each sticky flag three ways: set it by its own event, clear it with the matching strobe, and apply the strobes that must not touch it. A system reset between these steps separates the power-on domain flags from the wake flag. The divider is stepped to counts 1, 5, 63 and the wrap. The counts 1 and 5 have asymmetric bit patterns, so a count shown without the bit reversal is caught. The wrap shows whether the carry pulse comes once and in the right cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;
    parameter int WORD_W = 32;
    parameter int DID_W  = 4;
    parameter int DIV_W  = 6;

    localparam int B_MEDIA = 0;
    localparam int B_EXTP  = 1;
    localparam int B_WAKEL = 2;
    localparam int B_WAKEF = 3;
    localparam int B_DID   = 4;
    localparam int B_CTS   = B_DID + DID_W;
    localparam int B_DSR   = B_CTS + 1;
    localparam int B_DCD   = B_DSR + 1;
    localparam int B_BUSY  = B_DCD + 1;
    localparam int B_NBAT  = B_BUSY + 1;
    localparam int B_USR   = B_NBAT + 1;
    localparam int B_PF    = B_USR + 1;
    localparam int B_COLD  = B_PF + 1;
    localparam int B_DIV   = B_COLD + 1;

    // synchronised pin bundle, system reset domain
    localparam int SYS_PINS = 6 + DID_W;

    typedef struct packed {
        logic wake_prev;
        logic wake_flag;
    } sys_flag_t;

    typedef struct packed {
        logic bat_prev;
        logic nb_flag;
        logic usr_flag;
        logic pf_flag;
        logic cold_flag;
    } por_flag_t;
endpackage

// File: rtl/sts_sync.sv
module sts_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.meta <= RST_VAL;
            st_q.stab <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;
endmodule

// File: rtl/sts_flags.sv
module sts_flags
    import sts_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wake_s,
    input  logic bat_s,
    input  logic clr_wr,
    input  logic halt_wr,
    input  logic stdby_wr,
    input  logic rst_by_user,
    input  logic rst_by_pwrfail,
    output logic wake_flag,
    output logic nb_flag,
    output logic usr_flag,
    output logic pf_flag,
    output logic cold_flag
);
    localparam por_flag_t POR_INIT = '{bat_prev: 1'b1, nb_flag: 1'b0,
                                       usr_flag: 1'b0, pf_flag: 1'b0,
                                       cold_flag: 1'b1};

    sys_flag_t sys_d, sys_q;
    por_flag_t por_d, por_q;
    logic      wake_rise;
    logic      bat_rise;

    always_comb begin
        wake_rise       = wake_s & ~sys_q.wake_prev;
        sys_d           = sys_q;
        sys_d.wake_prev = wake_s;
        if (halt_wr || stdby_wr) sys_d.wake_flag = 1'b0;
        if (wake_rise)           sys_d.wake_flag = 1'b1;

        bat_rise       = bat_s & ~por_q.bat_prev;
        por_d          = por_q;
        por_d.bat_prev = bat_s;
        if (clr_wr) begin
            por_d.nb_flag   = 1'b0;
            por_d.usr_flag  = 1'b0;
            por_d.pf_flag   = 1'b0;
            por_d.cold_flag = 1'b0;
        end
        if (bat_rise)       por_d.nb_flag  = 1'b1;
        if (rst_by_user)    por_d.usr_flag = 1'b1;
        if (rst_by_pwrfail) por_d.pf_flag  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_q <= '0;
        else        sys_q <= sys_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) por_q <= POR_INIT;
        else        por_q <= por_d;
    end

    assign wake_flag = sys_q.wake_flag;
    assign nb_flag   = por_q.nb_flag;
    assign usr_flag  = por_q.usr_flag;
    assign pf_flag   = por_q.pf_flag;
    assign cold_flag = por_q.cold_flag;

    // R4
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_wr || stdby_wr) && !wake_rise) |=> !wake_flag);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_wr && rst_by_user) |=> usr_flag);

    // R7
    nb_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (nb_flag && !clr_wr) |=> nb_flag);

    // R9
    cold_stays_chk: assert property (@(posedge clk) disable iff (!por_n)
        !cold_flag |=> !cold_flag);
endmodule

// File: rtl/sts_divider.sv
module sts_divider
    import sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [DIV_W-1:0] field_o,
    output logic             carry_o
);
    localparam logic [DIV_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             carry;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.carry = 1'b0;
        if (tick) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.carry = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < DIV_W; i++) begin : g_rev
        assign field_o[DIV_W-1-i] = st_q.cnt[i];
    end

    assign carry_o = st_q.carry;

    // R11
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(field_o));

    // R12
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (field_o == '0));
endmodule

// File: rtl/sys_status_word.sv
module sys_status_word
    import sts_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              clr_wr,
    input  logic              halt_wr,
    input  logic              stdby_wr,
    input  logic              media_chg_pin,
    input  logic              ext_pwr_n_pin,
    input  logic              wake_pin,
    input  logic [DID_W-1:0]  lcd_data_pin,
    input  logic              cts_pin,
    input  logic              dsr_pin,
    input  logic              dcd_pin,
    input  logic              bat_chg_n_pin,
    input  logic              lcd_en,
    input  logic              uart_tx_busy,
    input  logic              rst_by_user,
    input  logic              rst_by_pwrfail,
    input  logic              tick64,
    output logic              rtc_inc
);
    typedef struct packed {
        logic [DID_W-1:0] did;
    } top_t;

    logic [SYS_PINS-1:0] pins_a, pins_s;
    logic                bat_s;
    logic                media_s, extp_n_s, wake_s, cts_s, dsr_s, dcd_s;
    logic [DID_W-1:0]    lcd_s;
    logic                wake_flag, nb_flag, usr_flag, pf_flag, cold_flag;
    logic [DIV_W-1:0]    div_field;
    logic [WORD_W-1:0]   word;
    top_t                top_d, top_q;

    assign pins_a = {lcd_data_pin, dcd_pin, dsr_pin, cts_pin,
                     wake_pin, ext_pwr_n_pin, media_chg_pin};

    sts_sync #(.W(SYS_PINS), .RST_VAL('0)) u_sync_sys (
        .clk     (clk),
        .arst_n  (rst_n),
        .async_i (pins_a),
        .sync_o  (pins_s)
    );

    sts_sync #(.W(1), .RST_VAL(1'b1)) u_sync_por (
        .clk     (clk),
        .arst_n  (por_n),
        .async_i (bat_chg_n_pin),
        .sync_o  (bat_s)
    );

    assign {lcd_s, dcd_s, dsr_s, cts_s, wake_s, extp_n_s, media_s} = pins_s;

    sts_flags u_flags (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .wake_s         (wake_s),
        .bat_s          (bat_s),
        .clr_wr         (clr_wr),
        .halt_wr        (halt_wr),
        .stdby_wr       (stdby_wr),
        .rst_by_user    (rst_by_user),
        .rst_by_pwrfail (rst_by_pwrfail),
        .wake_flag      (wake_flag),
        .nb_flag        (nb_flag),
        .usr_flag       (usr_flag),
        .pf_flag        (pf_flag),
        .cold_flag      (cold_flag)
    );

    sts_divider u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick64),
        .field_o (div_field),
        .carry_o (rtc_inc)
    );

    always_comb begin
        top_d = top_q;
        if (!lcd_en) top_d.did = lcd_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        word                          = '0;
        word[B_MEDIA]                 = ~media_s;
        word[B_EXTP]                  = ~extp_n_s;
        word[B_WAKEL]                 = wake_s;
        word[B_WAKEF]                 = wake_flag;
        word[B_DID +: DID_W]          = top_q.did;
        word[B_CTS]                   = cts_s;
        word[B_DSR]                   = dsr_s;
        word[B_DCD]                   = dcd_s;
        word[B_BUSY]                  = uart_tx_busy;
        word[B_NBAT]                  = nb_flag;
        word[B_USR]                   = usr_flag;
        word[B_PF]                    = pf_flag;
        word[B_COLD]                  = cold_flag;
        word[B_DIV +: DIV_W]          = div_field;
        rd_data                       = rd_sel ? word : '0;
    end

    // R5
    did_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |=> $stable(top_q.did));
endmodule

// File: tb/sys_status_word_test.sv
module sys_status_word_test;
    logic        clk = 1'b0;
    logic        por_n, rst_n, rd_sel;
    logic [31:0] rd_data;
    logic        clr_wr, halt_wr, stdby_wr;
    logic        media_chg_pin, ext_pwr_n_pin, wake_pin;
    logic [3:0]  lcd_data_pin;
    logic        cts_pin, dsr_pin, dcd_pin, bat_chg_n_pin;
    logic        lcd_en, uart_tx_busy, rst_by_user, rst_by_pwrfail, tick64;
    logic        rtc_inc;

    int checks = 0;
    int errors = 0;
    int rtc_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sys_status_word uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .rd_sel(rd_sel),
        .rd_data(rd_data), .clr_wr(clr_wr), .halt_wr(halt_wr),
        .stdby_wr(stdby_wr), .media_chg_pin(media_chg_pin),
        .ext_pwr_n_pin(ext_pwr_n_pin), .wake_pin(wake_pin),
        .lcd_data_pin(lcd_data_pin), .cts_pin(cts_pin), .dsr_pin(dsr_pin),
        .dcd_pin(dcd_pin), .bat_chg_n_pin(bat_chg_n_pin), .lcd_en(lcd_en),
        .uart_tx_busy(uart_tx_busy), .rst_by_user(rst_by_user),
        .rst_by_pwrfail(rst_by_pwrfail), .tick64(tick64), .rtc_inc(rtc_inc)
    );

    always @(negedge clk) if (rtc_inc) rtc_seen++;

    // {media, ext_pwr_n, cts, dsr, dcd, busy, exp b0, b1, b8, b9, b10, b11}
    localparam logic [11:0] VEC [6] = '{
        12'b010000_100000,
        12'b101000_011000,
        12'b000101_110101,
        12'b110010_000010,
        12'b011111_101111,
        12'b100001_010001
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] rev6(input logic [5:0] v);
        for (int i = 0; i < 6; i++) rev6[5-i] = v[i];
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick64 = 1'b1; step(1);
            tick64 = 1'b0; step(1);
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; step(1);
        s = 1'b0; step(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        por_n = 0; rst_n = 0; rd_sel = 1;
        clr_wr = 0; halt_wr = 0; stdby_wr = 0;
        media_chg_pin = 0; ext_pwr_n_pin = 1; wake_pin = 0;
        lcd_data_pin = 4'h0; cts_pin = 0; dsr_pin = 0; dcd_pin = 0;
        bat_chg_n_pin = 0; lcd_en = 0; uart_tx_busy = 0;
        rst_by_user = 0; rst_by_pwrfail = 0; tick64 = 0;
        step(3);
        por_n = 1; rst_n = 1;
        step(4);
        chk("R9 R1 reset word", rd_data, 32'h0000_8001);
        rd_sel = 0; step(1);
        chk("R13 deselected", rd_data, 32'h0);
        rd_sel = 1;

        // live pin table: R1 R2 R6 R13
        for (int v = 0; v < 6; v++) begin
            logic [31:0] exp;
            {media_chg_pin, ext_pwr_n_pin, cts_pin, dsr_pin, dcd_pin,
             uart_tx_busy} = VEC[v][11:6];
            step(3);
            exp = 32'h0000_8000;
            exp[0]  = VEC[v][5];
            exp[1]  = VEC[v][4];
            exp[8]  = VEC[v][3];
            exp[9]  = VEC[v][2];
            exp[10] = VEC[v][1];
            exp[11] = VEC[v][0];
            chk("R1 R2 R6 R13 live table", rd_data, exp);
        end
        media_chg_pin = 0; ext_pwr_n_pin = 1; cts_pin = 0; dsr_pin = 0;
        dcd_pin = 0; uart_tx_busy = 0;
        step(3);

        // R3 R4 wake
        wake_pin = 1; step(4);
        chk("R3 R4 wake set", rd_data & 32'hC, 32'hC);
        wake_pin = 0; step(3);
        chk("R4 wake sticky", rd_data & 32'hC, 32'h8);
        pulse(halt_wr);
        chk("R4 halt clears", rd_data & 32'hC, 32'h0);
        wake_pin = 1; step(4); wake_pin = 0; step(3);
        pulse(stdby_wr);
        chk("R4 standby clears", rd_data & 32'hC, 32'h0);
        // R10: clear strobe in the same cycle as the detected edge
        wake_pin = 1; step(2);
        halt_wr = 1; step(1); halt_wr = 0; step(1);
        chk("R10 wake set wins", rd_data & 32'h8, 32'h8);
        wake_pin = 0; step(3);
        pulse(halt_wr);

        // R5 display id
        lcd_data_pin = 4'hA; step(4);
        chk("R5 id follows", rd_data & 32'hF0, 32'hA0);
        lcd_en = 1; step(1);
        lcd_data_pin = 4'h5; step(4);
        chk("R5 id frozen", rd_data & 32'hF0, 32'hA0);
        lcd_en = 0; step(1);
        chk("R5 id resumes", rd_data & 32'hF0, 32'h50);

        // R10 R9 R8: user reset cause with clear in same cycle
        rst_by_user = 1; clr_wr = 1; step(1);
        rst_by_user = 0; clr_wr = 0; step(1);
        chk("R10 R9 set wins, cold cleared", rd_data & 32'hF000, 32'h2000);
        pulse(rst_by_pwrfail);
        chk("R8 power fail", rd_data & 32'hF000, 32'h6000);

        // R7 new battery
        bat_chg_n_pin = 1; step(4);
        chk("R7 battery edge", rd_data & 32'hF000, 32'h7000);
        pulse(halt_wr); pulse(stdby_wr);
        chk("R7 mode writes ignored", rd_data & 32'hF000, 32'h7000);

        // system reset: wake flag cleared, power-on domain kept
        wake_pin = 1; step(4); wake_pin = 0; step(3);
        tick(3);
        rst_n = 0; step(2); rst_n = 1; step(4);
        chk("R8 R7 R9 R4 survive sys reset", rd_data & 32'hF008, 32'h7000);
        chk("R11 reset clears divider", rd_data & 32'h3F_0000, 32'h0);
        pulse(clr_wr);
        chk("R8 R7 clear", rd_data & 32'hF000, 32'h0);

        // R11 R12 divider
        tick(1);
        chk("R11 count 1", {26'd0, rd_data[21:16]}, {26'd0, rev6(6'd1)});
        tick(4);
        chk("R11 count 5", {26'd0, rd_data[21:16]}, {26'd0, rev6(6'd5)});
        tick(58);
        chk("R11 count 63", {26'd0, rd_data[21:16]}, {26'd0, rev6(6'd63)});
        chk("R12 no early carry", rtc_seen, 0);
        tick(1);
        step(2);
        chk("R12 one carry", rtc_seen, 1);
        chk("R11 R13 wrap", rd_data & 32'hFFFF_0000, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule